// File: doc/BRIEF.md
# Key-Guarded Non-Volatile Byte Store Controller

This block sits on a small processor register bus and fronts a 64-byte non-volatile byte store. The store is modelled as a synchronous register array. Its slow programming time is modelled by a write latency, given as a number of clock cycles. Software reaches the store through four bus slots: a byte address, a data byte, a control/status byte and a key slot. The key slot has no storage behind it.

Reads are immediate. Software selects a byte, sets the fetch bit, and two cycles later the data slot holds the stored byte. Writes are deliberately awkward, so that runaway code cannot change the store by accident. Software must first set a write-permit bit. It must then write 55h and then AAh to the key slot, and the very next bus write must set the launch bit. While the write is in flight, the launch bit reads high. When the write finishes, a completion flag rises and drives an interrupt line. An external abort input kills a write in flight and leaves an error flag behind.

Top module: `nvs_ctrl`

## Requirements
- R1: After synchronous reset, the address slot (sel 0), data slot (sel 1) and control slot (sel 2) all read 00h.
- R2: The address slot keeps only the low 6 bits of a written byte. Writing FFh reads back as 3Fh.
- R3: A control write with bit 0 (fetch) set copies the addressed byte into the data slot. The byte is readable at the data slot two clock edges after the write edge.
- R4: The key slot (sel 3) always reads 00h, including after 55h or AAh has been written to it.
- R5: A write is launched only by a control write with bit 1 (launch) set, and only when all of these hold: control bit 2 (write permit) was already 1 before that write, and the two bus writes just before it were 55h then AAh to the key slot.
- R6: Once launched, control bit 1 reads 1 for exactly WR_LAT clock edges. The byte that was in the data slot at launch is then committed to the address that was in the address slot at launch, and control bit 4 (done) is set.
- R7: The launch is refused, and the store is unchanged, when any other bus write comes between 55h and AAh, or when the key slot receives a wrong value.
- R8: Setting the launch bit while the write permit is 0 has no effect, even after a valid key sequence.
- R9: Raising ext_abort during a write in flight ends the write on the next edge. Control bit 3 (error) is set, bit 1 clears, bit 4 stays 0 and the store is unchanged.
- R10: The done_irq output equals control bit 4. Software clears bits 3 and 4 by writing 0 to them.
- R11: Bus writes to the data slot while a write is in flight do not change the byte being committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Slot select: 0 address, 1 data, 2 control, 3 key |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected slot |
| ext_abort | input | 1 | External abort of a write in flight |
| done_irq | output | 1 | Write-completion flag |

## Verification
A key sequencer left in the wrong state shows up at the control slot on the next edge: either a launch that should not happen, seen as bit 1 reading high, or a refused launch, seen as bit 1 staying low. A latency counter that is off by one changes the count of edges for which bit 1 stays high, and the bench measures that count exactly. A wrong captured address or data byte cannot be seen until the byte is fetched back. For that reason every committed or refused write is followed by a fetch of the affected address.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_KEY  = 2'd3
  } slot_e;

  localparam int B_FETCH  = 0;
  localparam int B_LAUNCH = 1;
  localparam int B_PERMIT = 2;
  localparam int B_ERR    = 3;
  localparam int B_DONE   = 4;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/nvs_key_seq.sv
module nvs_key_seq
  import nvs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic       armed
);
  typedef enum logic [1:0] {K_IDLE, K_HALF, K_ARMED} key_st_e;
  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (bus_wr) begin
      if (bus_sel == SEL_KEY) begin
        if (st_q == K_HALF)
          st_d = (bus_wdata == KEY_SECOND) ? K_ARMED : K_IDLE;
        else
          st_d = (bus_wdata == KEY_FIRST) ? K_HALF : K_IDLE;
      end else begin
        st_d = K_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= K_IDLE;
    else     st_q <= st_d;
  end

  assign armed = (st_q == K_ARMED);
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/nvs_wtimer.sv
module nvs_wtimer #(
  parameter int WR_LAT = 16,
  localparam int CW    = $clog2(WR_LAT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic finish,
  output logic killed
);
  logic [CW-1:0] cnt_q;

  assign finish = busy && !abort && (cnt_q == '0);
  assign killed = busy && abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      if (abort || cnt_q == '0) busy <= 1'b0;
      else                      cnt_q <= cnt_q - 1'b1;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= CW'(WR_LAT - 1);
    end
  end
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WR_LAT = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ext_abort,
  output logic       done_irq
);
  logic [AW-1:0] addr_q, lat_addr_q;
  logic [7:0]    data_q, lat_data_q, mem_q;
  logic          permit_q, err_q, done_q, fetch_q;
  logic          key_armed, busy, finish, killed;
  logic          ctrl_wr, start, fetch_go;

  assign ctrl_wr  = bus_wr && (bus_sel == SEL_CTRL);
  assign start    = ctrl_wr && bus_wdata[B_LAUNCH] && permit_q && key_armed && !busy;
  assign fetch_go = ctrl_wr && bus_wdata[B_FETCH];

  nvs_key_seq u_key (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .armed(key_armed)
  );

  nvs_wtimer #(.WR_LAT(WR_LAT)) u_tmr (
    .clk(clk), .rst(rst), .start(start), .abort(ext_abort),
    .busy(busy), .finish(finish), .killed(killed)
  );

  nvs_array #(.DEPTH(DEPTH), .DW(8)) u_mem (
    .clk(clk), .we(finish), .waddr(lat_addr_q), .wdata(lat_data_q),
    .re(fetch_go), .raddr(addr_q), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      data_q     <= '0;
      permit_q   <= 1'b0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
      fetch_q    <= 1'b0;
      lat_addr_q <= '0;
      lat_data_q <= '0;
    end else begin
      fetch_q <= fetch_go;
      if (bus_wr && bus_sel == SEL_ADDR) addr_q <= bus_wdata[AW-1:0];
      if (fetch_q)                            data_q <= mem_q;
      else if (bus_wr && bus_sel == SEL_DATA) data_q <= bus_wdata;
      if (ctrl_wr) begin
        permit_q <= bus_wdata[B_PERMIT];
        err_q    <= bus_wdata[B_ERR];
        done_q   <= bus_wdata[B_DONE];
      end
      if (finish) done_q <= 1'b1;
      if (killed) err_q  <= 1'b1;
      if (start) begin
        lat_addr_q <= addr_q;
        lat_data_q <= data_q;
      end
    end
  end

  always_comb begin
    unique case (bus_sel)
      SEL_ADDR: bus_rdata = {{(8-AW){1'b0}}, addr_q};
      SEL_DATA: bus_rdata = data_q;
      SEL_CTRL: bus_rdata = {3'b000, done_q, err_q, permit_q, busy, fetch_q};
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign done_irq = done_q;
endmodule

// File: rtl/nvs_checker.sv
module nvs_checker
  import nvs_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [1:0] bus_sel,
  input logic [7:0] bus_rdata,
  input logic       ext_abort,
  input logic       done_irq,
  input logic       busy,
  input logic       armed,
  input logic       permit,
  input logic       err
);
  p_launch_needs_key_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(armed) && $past(permit)));

  p_key_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_sel == SEL_KEY) |-> (bus_rdata == 8'h00));

  p_abort_sets_err_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && ext_abort) |=> (!busy && err));

  p_done_after_write_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(ext_abort)) |-> done_irq);

  p_irq_mirrors_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_sel == SEL_CTRL) |-> (bus_rdata[B_DONE] == done_irq));
endmodule

bind nvs_ctrl nvs_checker u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rdata(bus_rdata),
  .ext_abort(ext_abort), .done_irq(done_irq), .busy(busy),
  .armed(key_armed), .permit(permit_q), .err(err_q)
);

// File: tb/tb_nvs_ctrl.sv
module tb_nvs_ctrl;
  localparam int LAT = 12;
  localparam int NV  = 6;
  localparam logic [13:0] VEC [NV] = '{
    {6'h00, 8'hA5}, {6'h3F, 8'h5A}, {6'h15, 8'hFF},
    {6'h2A, 8'h00}, {6'h01, 8'h3C}, {6'h3E, 8'hC3}
  };

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, ext_abort = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic done_irq;
  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nvs_ctrl #(.WR_LAT(LAT)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_abort(ext_abort), .done_irq(done_irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [1:0] s, input logic [7:0] d);
    bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] s, output logic [7:0] v);
    bus_sel = s; #1; v = bus_rdata;
  endtask

  task automatic fetch(input logic [5:0] a, output logic [7:0] v);
    bw(2'd0, {2'b00, a});
    bw(2'd2, 8'h05);
    @(negedge clk);
    peek(2'd1, v);
  endtask

  task automatic keyed_launch(input logic [5:0] a, input logic [7:0] d);
    bw(2'd0, {2'b00, a});
    bw(2'd1, d);
    bw(2'd2, 8'h04);
    bw(2'd3, 8'h55);
    bw(2'd3, 8'hAA);
    bw(2'd2, 8'h06);
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] v;
    n = 0;
    peek(2'd2, v);
    while (v[1] && n < 1000) begin
      @(negedge clk); n++; peek(2'd2, v);
    end
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk); cyc++;
      if (cyc > 50000) begin
        fails++; tests++;
        $display("FAIL watchdog: actual %0d expected <50000 cycles", cyc);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    peek(2'd0, v); chk("R1 addr reset", v, 8'h00);
    peek(2'd1, v); chk("R1 data reset", v, 8'h00);
    peek(2'd2, v); chk("R1 ctrl reset", v, 8'h00);

    bw(2'd0, 8'hFF); peek(2'd0, v); chk("R2 addr width", v, 8'h3F);

    for (int i = 0; i < NV; i++) begin
      keyed_launch(VEC[i][13:8], VEC[i][7:0]);
      peek(2'd2, v); chk("R6 launch bit high", {7'd0, v[1]}, 8'h01);
      wait_idle(n);
      chk("R6 latency", 8'(n), 8'(LAT));
      peek(2'd2, v); chk("R6 done flag", v, 8'h14);
      chk("R10 irq high", {7'd0, done_irq}, 8'h01);
      bw(2'd2, 8'h04);
      chk("R10 irq cleared", {7'd0, done_irq}, 8'h00);
    end
    for (int i = 0; i < NV; i++) begin
      fetch(VEC[i][13:8], v); chk("R3 fetch back", v, VEC[i][7:0]);
    end
    peek(2'd2, v); chk("R3 fetch bit self-clears", v, 8'h04);

    bw(2'd3, 8'h55); bw(2'd3, 8'hAA);
    peek(2'd3, v); chk("R4 key reads zero", v, 8'h00);

    keyed_launch(6'h05, 8'h11); wait_idle(n); bw(2'd2, 8'h04);
    bw(2'd2, 8'h00); bw(2'd3, 8'h55); bw(2'd3, 8'hAA); bw(2'd2, 8'h02);
    peek(2'd2, v); chk("R8 no launch without permit", v, 8'h00);
    fetch(6'h05, v); chk("R8 store unchanged", v, 8'h11);

    bw(2'd1, 8'h99);
    bw(2'd3, 8'h55); bw(2'd1, 8'h99); bw(2'd3, 8'hAA); bw(2'd2, 8'h06);
    peek(2'd2, v); chk("R7 intervening write refused", v, 8'h04);
    bw(2'd3, 8'h55); bw(2'd3, 8'hAB); bw(2'd2, 8'h06);
    peek(2'd2, v); chk("R7 wrong key refused", v, 8'h04);
    bw(2'd3, 8'h55); bw(2'd3, 8'h55); bw(2'd3, 8'hAA); bw(2'd2, 8'h06);
    peek(2'd2, v); chk("R7 repeated first key refused", v, 8'h04);
    fetch(6'h05, v); chk("R7 store unchanged", v, 8'h11);

    keyed_launch(6'h05, 8'h22);
    bw(2'd1, 8'h33);
    wait_idle(n);
    fetch(6'h05, v); chk("R11 captured byte committed", v, 8'h22);
    bw(2'd2, 8'h04);

    keyed_launch(6'h05, 8'h44);
    repeat (3) @(negedge clk);
    ext_abort = 1'b1; @(negedge clk); ext_abort = 1'b0;
    peek(2'd2, v); chk("R9 abort flags", v, 8'h0C);
    chk("R9 irq stays low", {7'd0, done_irq}, 8'h00);
    fetch(6'h05, v); chk("R9 store unchanged", v, 8'h22);
    bw(2'd2, 8'h04);
    peek(2'd2, v); chk("R10 err cleared by software", v, 8'h04);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule